// File: doc/BRIEF.md
# Early-Done Asymmetric Completion Detector

This block watches the dual-rail inputs of a pipeline stage together with that stage's precharge control. It produces a single `done` flag that announces the stage's next phase while that phase is still under way. It sits on the input side of the stage, ahead of the function block. Its completion report therefore overlaps the stage's own evaluation or precharge, and does not follow it.

For each bit, the two rails are ORed to form a per-bit validity flag. These flags feed an asymmetric C-element. The flag is set only when the stage is in evaluate mode and every bit is valid. It is cleared whenever the stage is in precharge, whatever the data are. In all other cases it keeps its value. The block is clocked, and the C-element state is one register that is cleared by an active-low asynchronous reset. The width is a parameter.

Top module: `early_done_detector`

## Requirements
- R1: Bit i counts as valid when `rail_t[i]` or `rail_f[i]` is 1. It does not matter which rail carries the token.
- R2: If `pc` is 0 and every bit is valid at a rising clock edge, `done` is 1 after that edge.
- R3: If `pc` is 1 at a rising clock edge, `done` is 0 after that edge, whatever the rail values are.
- R4: If `pc` is 0 and at least one bit has both rails at 0, `done` keeps its previous value across the edge.
- R5: While `rst_n` is low, `done` is 0.
- R6: A partially valid input (any proper subset of bits valid, with `pc` 0) never lets `done` rise from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc | input | 1 | Stage precharge control: 1 = precharge, 0 = evaluate |
| rail_t | input | WIDTH | True rail of each input bit |
| rail_f | input | WIDTH | False rail of each input bit |
| done | output | 1 | Early completion flag |

## Verification
All of the block's state is the single C-element bit, and `done` shows it directly. A wrong state therefore appears at the port one clock after the edge that produced it. A missing hold term shows up as `done` dropping during a partial-valid evaluate cycle that follows a completed one. A wrong reduction shows up as an early rise on a vector with one bit empty. The bench sweeps every single-missing-bit pattern and a few multi-bit gaps. It also exercises precharge with full, empty and random data, so a fall condition that wrongly depends on the data is exposed in the next cycle.

// File: rtl/early_done_detector.sv
module early_done_detector #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pc,
  input  logic [WIDTH-1:0] rail_t,
  input  logic [WIDTH-1:0] rail_f,
  output logic             done
);
  logic [WIDTH-1:0] bit_ok;
  logic             all_ok;
  logic             set_c, clr_c;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bit_ok[i] = rail_t[i] | rail_f[i];
  end

  assign all_ok = &bit_ok;
  assign set_c  = !pc && all_ok;
  assign clr_c  = pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     done <= 1'b0;
    else if (clr_c) done <= 1'b0;
    else if (set_c) done <= 1'b1;
  end
endmodule

// File: rtl/early_done_detector_chk.sv
module early_done_detector_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pc,
  input logic [WIDTH-1:0] rail_t,
  input logic [WIDTH-1:0] rail_f,
  input logic             done
);
  logic full;
  assign full = ((rail_t | rail_f) == {WIDTH{1'b1}});

  a_r2_rise_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc && full) |=> done);
  a_r3_fall_on_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    pc |=> !done);
  a_r4_hold_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc && !full) |=> $stable(done));
  a_r6_no_early_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc && !full && !done) |=> !done);
  a_r5_reset_low: assert property (@(posedge clk)
    !rst_n |-> !done);
endmodule

bind early_done_detector early_done_detector_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc), .rail_t(rail_t), .rail_f(rail_f), .done(done)
);

// File: tb/tb_early_done_detector.sv
module tb_early_done_detector;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pc = 1'b1;
  logic [W-1:0] rail_t = '0;
  logic [W-1:0] rail_f = '0;
  logic         done;

  int checks = 0;
  int failures = 0;
  bit exp_done = 1'b0;
  bit finished = 1'b0;

  early_done_detector #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .pc(pc), .rail_t(rail_t), .rail_f(rail_f), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit vec_valid(logic [W-1:0] t, logic [W-1:0] f);
    for (int i = 0; i < W; i++) if (!(t[i] || f[i])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit next_done(bit cur, bit p, logic [W-1:0] t, logic [W-1:0] f);
    if (p) return 1'b0;
    if (vec_valid(t, f)) return 1'b1;
    return cur;
  endfunction

  function automatic string req_of(bit cur, bit p, logic [W-1:0] t, logic [W-1:0] f);
    if (p) return "R3";
    if (vec_valid(t, f)) return "R2";
    if (!cur) return "R6";
    return "R4";
  endfunction

  task automatic check(string req, bit exp);
    checks++;
    if (done !== exp) begin
      failures++;
      $display("FAIL %s: done=%0b expected=%0b", req, done, exp);
    end
  endtask

  task automatic step(bit p, logic [W-1:0] t, logic [W-1:0] f, string tag = "");
    string r;
    @(negedge clk);
    pc = p; rail_t = t; rail_f = f;
    r = (tag != "") ? tag : req_of(exp_done, p, t, f);
    exp_done = next_done(exp_done, p, t, f);
    @(posedge clk);
    #1;
    check(r, exp_done);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: done=%0b expected=completion", done);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] t, f, m;
    void'($urandom(32'h5eed_0042));
    // R5: reset state, even with full valid evaluate input applied
    pc = 1'b0; rail_t = '1; rail_f = '0;
    repeat (3) @(posedge clk);
    #1; check("R5", 1'b0);
    @(negedge clk); rst_n = 1'b1; pc = 1'b1;
    exp_done = 1'b0;

    // R6: every single-missing-bit pattern, random rail choice
    for (int i = 0; i < W; i++) begin
      t = W'($urandom); f = ~t; t[i] = 1'b0; f[i] = 1'b0;
      step(1'b0, t, f, "R6");
    end
    // R6: growing prefix of valid bits
    for (int k = 0; k < W; k++) begin
      m = (W'(1) << k) - 1'b1;
      step(1'b0, m, '0, "R6");
    end
    // R1: valid via true rails only, then false rails only
    step(1'b0, '1, '0, "R1");
    step(1'b1, '1, '0, "R3");
    step(1'b0, '0, '1, "R1");
    step(1'b1, '0, '0, "R3");
    // R1: alternating rails
    step(1'b0, {W/2{2'b10}}, {W/2{2'b01}}, "R1");
    // R4: hold high through empty and partial data
    step(1'b0, '0, '0, "R4");
    step(1'b0, {W/2{2'b01}}, '0, "R4");
    // R3: precharge with full data clears
    step(1'b1, '1, '1, "R3");
    // R4: hold low
    step(1'b0, '0, {W/2{2'b01}}, "R6");
    // R2 then R3 with random data
    step(1'b0, '1, '1, "R2");
    step(1'b1, W'($urandom), W'($urandom), "R3");

    // random mix; bias toward partially valid vectors
    for (int n = 0; n < 600; n++) begin
      bit p;
      p = ($urandom % 4) == 0;
      t = W'($urandom); f = W'($urandom);
      if (($urandom % 3) != 0) begin
        f = ~t;
        if ($urandom % 2) begin
          int b;
          b = int'($urandom % W);
          t[b] = 1'b0; f[b] = 1'b0;
        end
      end
      step(p, t, f);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule